// File: doc/BRIEF.md
# DMA Controller Register Bank with Interrupt Status

This block is the register face of a multi-channel DMA controller. A 32-bit register bus reaches three regions. The global words hold interrupt status, interrupt clears, the enabled-channel bitmap, a global configuration word and a sync word. Each channel has its own set of five words. A small window at the top of the space returns identification bytes. A parameter selects either eight or two channels.

The transfer engine sits beside this block. It reads every channel's words over flat output buses. It reports finished transfers and bus errors as one-cycle set pulses per channel. The block keeps raw terminal-count and error vectors and masks them with enable bits taken from each channel's configuration word. It drives a single interrupt line from the masked bits.

The bus handshake takes one cycle. An access is taken on a cycle where `bus_valid` is high and `bus_ready` is low. `bus_ready` is then high for exactly one cycle, and `bus_rdata` holds the registered read result in that cycle. The master drops `bus_valid` when it sees `bus_ready`.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every storage word, both interrupt vectors, `irq` and `bus_ready` are zero.
- R2: The five words of channel c are source (word 0), destination (word 1), link pointer (word 2), control (word 3) and configuration (word 4), at byte address 0x100 + 32*c + 4*word. Each word is 32 bits, can be read back, and drives the engine output slice [32*c +: 32].
- R3: A channel-region address (0x100 to 0x1FF) whose channel index, address bits [7:5], is at or above `NCH`, or whose word index, bits [4:2], is 5 to 7, reads zero and changes no state on a write.
- R4: Global words are selected by address bits [7:2] for addresses below 0x100. Word 0 holds masked terminal-count OR masked error. Word 1 holds masked terminal-count. Word 3 holds masked error. Word 5 holds raw terminal-count. Word 6 holds raw error. Word 7 holds the enabled bitmap, bit c being configuration bit 0 of channel c. Word 12 is a 32-bit read/write global configuration and word 13 a 32-bit read/write sync word. Bit c of each status word belongs to channel c and the upper bits read zero.
- R5: Channel c's terminal-count mask bit is its configuration bit 15 and its error mask bit is its configuration bit 14. Raw bits are kept whatever the mask.
- R6: Writing global word 2 clears each raw terminal-count bit whose write-data bit is 1. Writing global word 4 does the same for raw error bits. Other bits are untouched.
- R7: When an engine set pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when some masked terminal-count or masked error bit is 1.
- R9: Addresses 0xFE0 to 0xFFF return one byte per word: 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1 for eight channels. The two-channel variant returns the same bytes except that the first is 0x81.
- R10: Global words 8 to 11 and all other unmapped addresses read zero, and writes to them change no state.
- R11: An access is taken when `bus_valid` is high and `bus_ready` is low. `bus_ready` is high in the next cycle only, and `bus_rdata` holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completed, read data valid |
| bus_rdata | output | 32 | Registered read data |
| tc_set | input | NCH | Per-channel terminal-count set pulses |
| err_set | input | NCH | Per-channel error set pulses |
| ch_src | output | 32*NCH | Source words of all channels |
| ch_dst | output | 32*NCH | Destination words of all channels |
| ch_link | output | 32*NCH | Link pointer words of all channels |
| ch_ctrl | output | 32*NCH | Control words of all channels |
| ch_cfg | output | 32*NCH | Configuration words of all channels |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a software clear and an engine set pulse landing on the same status bit in the same clock. The bench times the set pulse so that it is driven in the very cycle where the clear write is accepted, on a channel that already has the bit raised. It then reads back both the raw and the masked views. Other stimulus raises bits on channels whose masks differ, so raw and masked words disagree. It also writes to channel slots beyond the two-channel count while a behavioural model compares every engine output on every clock.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] cfg;
    } chan_regs_t;

    typedef enum logic [2:0] {
        CW_SRC  = 3'd0,
        CW_DST  = 3'd1,
        CW_LINK = 3'd2,
        CW_CTRL = 3'd3,
        CW_CFG  = 3'd4
    } chan_word_e;

    localparam int CFG_EN_BIT      = 0;
    localparam int CFG_ERRMASK_BIT = 14;
    localparam int CFG_TCMASK_BIT  = 15;

    localparam logic [5:0] GW_STAT     = 6'd0;
    localparam logic [5:0] GW_TC_STAT  = 6'd1;
    localparam logic [5:0] GW_TC_CLR   = 6'd2;
    localparam logic [5:0] GW_ERR_STAT = 6'd3;
    localparam logic [5:0] GW_ERR_CLR  = 6'd4;
    localparam logic [5:0] GW_TC_RAW   = 6'd5;
    localparam logic [5:0] GW_ERR_RAW  = 6'd6;
    localparam logic [5:0] GW_ENABLED  = 6'd7;
    localparam logic [5:0] GW_GCFG     = 6'd12;
    localparam logic [5:0] GW_SYNC     = 6'd13;

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input logic two_ch);
        case (idx)
            3'd0:    id_byte = two_ch ? 8'h81 : 8'h80;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h0A;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        word,
    input  logic [WORD_W-1:0] wdata,
    output chan_regs_t        regs
);

    chan_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (word)
                CW_SRC:  regs_d.src  = wdata;
                CW_DST:  regs_d.dst  = wdata;
                CW_LINK: regs_d.link = wdata;
                CW_CTRL: regs_d.ctrl = wdata;
                CW_CFG:  regs_d.cfg  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs)); // R3

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tc_set,
    input  logic [NCH-1:0] err_set,
    input  logic           tc_clr,
    input  logic           err_clr,
    input  logic [NCH-1:0] clr_bits,
    input  logic [NCH-1:0] tc_mask,
    input  logic [NCH-1:0] err_mask,
    output logic [NCH-1:0] tc_raw,
    output logic [NCH-1:0] err_raw,
    output logic           irq
);

    typedef struct packed {
        logic [NCH-1:0] tc;
        logic [NCH-1:0] err;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tc_clr)  st_d.tc  = st_d.tc  & ~clr_bits;
        if (err_clr) st_d.err = st_d.err & ~clr_bits;
        st_d.tc  = st_d.tc  | tc_set;
        st_d.err = st_d.err | err_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tc_raw  = st_q.tc;
    assign err_raw = st_q.err;
    assign irq     = |((st_q.tc & tc_mask) | (st_q.err & err_mask));

    AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_set != '0) |=> ((tc_raw & $past(tc_set)) == $past(tc_set))); // R7
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != '0) |=> ((err_raw & $past(err_set)) == $past(err_set))); // R7
    AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clr && tc_set == '0) |=> ((tc_raw & $past(clr_bits)) == '0)); // R6
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((tc_raw | err_raw) != '0)); // R8

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_regbank_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    tc_set,
    input  logic [NCH-1:0]    err_set,
    output logic [32*NCH-1:0] ch_src,
    output logic [32*NCH-1:0] ch_dst,
    output logic [32*NCH-1:0] ch_link,
    output logic [32*NCH-1:0] ch_ctrl,
    output logic [32*NCH-1:0] ch_cfg,
    output logic              irq
);

    localparam int PAD = WORD_W - NCH;
    localparam logic TWO_CH = (NCH == 2);

    typedef struct packed {
        logic              ready;
        logic [WORD_W-1:0] rdata;
        logic [WORD_W-1:0] gcfg;
        logic [WORD_W-1:0] sync;
    } top_state_t;

    top_state_t st_d, st_q;

    chan_regs_t     regs [NCH];
    logic [NCH-1:0] ch_wr;
    logic [NCH-1:0] tc_mask, err_mask, en_map;
    logic [NCH-1:0] tc_raw, err_raw;

    logic       accept, wr_acc;
    logic       in_chan, in_glob, in_id, ch_hit;
    logic [2:0] ch_idx, ch_word;
    logic [5:0] gword;

    assign accept  = bus_valid & ~st_q.ready;
    assign wr_acc  = accept & bus_write;
    assign in_chan = (bus_addr[11:8] == 4'h1);
    assign in_glob = (bus_addr[11:8] == 4'h0);
    assign in_id   = (bus_addr[11:5] == 7'h7F);
    assign ch_idx  = bus_addr[7:5];
    assign ch_word = bus_addr[4:2];
    assign gword   = bus_addr[7:2];
    assign ch_hit  = in_chan && (int'(ch_idx) < NCH) && (ch_word <= CW_CFG);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign ch_wr[c] = wr_acc & ch_hit & (int'(ch_idx) == c);

        dma_chan_regs i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (ch_wr[c]),
            .word  (ch_word),
            .wdata (bus_wdata),
            .regs  (regs[c])
        );

        assign ch_src [32*c +: 32] = regs[c].src;
        assign ch_dst [32*c +: 32] = regs[c].dst;
        assign ch_link[32*c +: 32] = regs[c].link;
        assign ch_ctrl[32*c +: 32] = regs[c].ctrl;
        assign ch_cfg [32*c +: 32] = regs[c].cfg;
        assign tc_mask[c]  = regs[c].cfg[CFG_TCMASK_BIT];
        assign err_mask[c] = regs[c].cfg[CFG_ERRMASK_BIT];
        assign en_map[c]   = regs[c].cfg[CFG_EN_BIT];
    end

    dma_irq_status #(.NCH(NCH)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_set   (tc_set),
        .err_set  (err_set),
        .tc_clr   (wr_acc & in_glob & (gword == GW_TC_CLR)),
        .err_clr  (wr_acc & in_glob & (gword == GW_ERR_CLR)),
        .clr_bits (bus_wdata[NCH-1:0]),
        .tc_mask  (tc_mask),
        .err_mask (err_mask),
        .tc_raw   (tc_raw),
        .err_raw  (err_raw),
        .irq      (irq)
    );

    logic [WORD_W-1:0] rd_val;
    chan_regs_t        sel;

    always_comb begin
        sel = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(ch_idx) == c) sel = regs[c];
        end
        rd_val = '0;
        if (ch_hit) begin
            case (ch_word)
                CW_SRC:  rd_val = sel.src;
                CW_DST:  rd_val = sel.dst;
                CW_LINK: rd_val = sel.link;
                CW_CTRL: rd_val = sel.ctrl;
                default: rd_val = sel.cfg;
            endcase
        end else if (in_id) begin
            rd_val = {24'd0, id_byte(bus_addr[4:2], TWO_CH)};
        end else if (in_glob) begin
            case (gword)
                GW_STAT:     rd_val = {{PAD{1'b0}}, (tc_raw & tc_mask) | (err_raw & err_mask)};
                GW_TC_STAT:  rd_val = {{PAD{1'b0}}, tc_raw & tc_mask};
                GW_ERR_STAT: rd_val = {{PAD{1'b0}}, err_raw & err_mask};
                GW_TC_RAW:   rd_val = {{PAD{1'b0}}, tc_raw};
                GW_ERR_RAW:  rd_val = {{PAD{1'b0}}, err_raw};
                GW_ENABLED:  rd_val = {{PAD{1'b0}}, en_map};
                GW_GCFG:     rd_val = st_q.gcfg;
                GW_SYNC:     rd_val = st_q.sync;
                default:     rd_val = '0;
            endcase
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.ready = accept;
        if (accept) st_d.rdata = bus_write ? '0 : rd_val;
        if (wr_acc && in_glob && gword == GW_GCFG) st_d.gcfg = bus_wdata;
        if (wr_acc && in_glob && gword == GW_SYNC) st_d.sync = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_ready = st_q.ready;
    assign bus_rdata = st_q.rdata;

    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> bus_ready); // R11
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && $past(bus_addr[11:8] == 4'h1 && int'(bus_addr[7:5]) >= NCH))
        |-> (bus_rdata == '0)); // R3
    AST_SOFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && $past(bus_addr[11:4] == 8'h02)) |-> (bus_rdata == '0)); // R10

endmodule

// File: tb/test_dma_regbank.sv
`timescale 1ns/1ps
module test_dma_regbank;

    localparam int NCH = 2;
    localparam real TCLK = 20.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ready;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    tc_set = '0;
    logic [NCH-1:0]    err_set = '0;
    logic [32*NCH-1:0] ch_src, ch_dst, ch_link, ch_ctrl, ch_cfg;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(TCLK/2) clk = ~clk;

    dma_regbank #(.NCH(NCH)) i_dma_regbank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .tc_set(tc_set), .err_set(err_set),
        .ch_src(ch_src), .ch_dst(ch_dst), .ch_link(ch_link), .ch_ctrl(ch_ctrl),
        .ch_cfg(ch_cfg), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0]    m_chan [NCH][5];
    logic [31:0]    m_gcfg, m_sync;
    logic [NCH-1:0] m_tc, m_err;
    logic           m_ready;

    function automatic logic [NCH-1:0] m_tcmask();
        for (int c = 0; c < NCH; c++) m_tcmask[c] = m_chan[c][4][15];
    endfunction
    function automatic logic [NCH-1:0] m_errmask();
        for (int c = 0; c < NCH; c++) m_errmask[c] = m_chan[c][4][14];
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [7:0] ids [8];
        ids = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (a >= 'h100 && a < 'h200) begin
            int ch = (a >> 5) & 7;
            int w = (a >> 2) & 7;
            if (ch < NCH && w < 5) return m_chan[ch][w];
            return 0;
        end
        if (a >= 'hFE0) return 32'(ids[(a - 'hFE0) >> 2]);
        if (a < 'h100) begin
            case (a >> 2)
                0: return 32'((m_tc & m_tcmask()) | (m_err & m_errmask()));
                1: return 32'(m_tc & m_tcmask());
                3: return 32'(m_err & m_errmask());
                5: return 32'(m_tc);
                6: return 32'(m_err);
                7: begin
                    logic [NCH-1:0] e;
                    for (int c = 0; c < NCH; c++) e[c] = m_chan[c][0+4][0];
                    return 32'(e);
                end
                12: return m_gcfg;
                13: return m_sync;
                default: return 0;
            endcase
        end
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) for (int w = 0; w < 5; w++) m_chan[c][w] = 0;
            m_gcfg = 0; m_sync = 0; m_tc = 0; m_err = 0; m_ready = 0;
        end else begin
            bit acc;
            int a;
            acc = bus_valid && !m_ready;
            a = int'(bus_addr);
            if (acc && bus_write) begin
                if (a >= 'h100 && a < 'h200) begin
                    if (((a >> 5) & 7) < NCH && ((a >> 2) & 7) < 5)
                        m_chan[(a >> 5) & 7][(a >> 2) & 7] = bus_wdata;
                end else if (a < 'h100) begin
                    if ((a >> 2) == 2)  m_tc  = m_tc  & ~bus_wdata[NCH-1:0];
                    if ((a >> 2) == 4)  m_err = m_err & ~bus_wdata[NCH-1:0];
                    if ((a >> 2) == 12) m_gcfg = bus_wdata;
                    if ((a >> 2) == 13) m_sync = bus_wdata;
                end
            end
            m_tc  = m_tc  | tc_set;
            m_err = m_err | err_set;
            m_ready = acc;
        end
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8", "irq", 32'(irq),
                  32'(|((m_tc & m_tcmask()) | (m_err & m_errmask()))));
            check("R11", "ready", 32'(bus_ready), 32'(m_ready));
            for (int c = 0; c < NCH; c++) begin
                check("R2", "src port",  ch_src [32*c +: 32], m_chan[c][0]);
                check("R2", "dst port",  ch_dst [32*c +: 32], m_chan[c][1]);
                check("R2", "link port", ch_link[32*c +: 32], m_chan[c][2]);
                check("R2", "ctrl port", ch_ctrl[32*c +: 32], m_chan[c][3]);
                check("R2", "cfg port",  ch_cfg [32*c +: 32], m_chan[c][4]);
            end
        end
    end

    task automatic bus_wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 12'(a); bus_wdata = d;
        @(negedge clk);
        check("R11", "write ready", 32'(bus_ready), 1);
        bus_valid = 0; bus_write = 0;
        @(negedge clk);
    endtask

    task automatic bus_rd(int a, string tag);
        logic [31:0] exp;
        @(negedge clk);
        check("R11", "ready idle", 32'(bus_ready), 0);
        bus_valid = 1; bus_write = 0; bus_addr = 12'(a);
        exp = m_read(a);
        @(negedge clk);
        check("R11", "read ready", 32'(bus_ready), 1);
        check(tag, $sformatf("read %h", a), bus_rdata, exp);
        bus_valid = 0;
        @(negedge clk);
    endtask

    task automatic pulse(logic [NCH-1:0] t, logic [NCH-1:0] e);
        @(negedge clk);
        tc_set = t; err_set = e;
        @(negedge clk);
        tc_set = 0; err_set = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(TCLK * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1", "irq reset", 32'(irq), 0);
        check("R1", "ready reset", 32'(bus_ready), 0);
        bus_rd('h100, "R1");
        bus_rd('h030, "R1");
        bus_rd('h014, "R1");
        // R2: channel words
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 5; w++)
                bus_wr('h100 + 32*c + 4*w, 32'hA500_0000 + 32'(c*16 + w) + (w == 4 ? 32'h0 : 32'h0));
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 5; w++) bus_rd('h100 + 32*c + 4*w, "R2");
        // R3: out-of-range channel and word slots
        bus_wr('h140, 32'hDEAD_BEEF);
        bus_wr('h1E0, 32'h1234_5678);
        bus_wr('h114, 32'hFFFF_FFFF);
        bus_rd('h140, "R3");
        bus_rd('h1F0, "R3");
        bus_rd('h114, "R3");
        bus_rd('h100, "R3");
        // R4: global config, sync, enabled map
        bus_wr('h030, 32'hCAFE_0001);
        bus_wr('h034, 32'h0000_00F3);
        bus_rd('h030, "R4");
        bus_rd('h034, "R4");
        bus_wr('h110, 32'h0000_8001);   // ch0: tc mask, enabled
        bus_wr('h130, 32'h0000_4000);   // ch1: error mask only
        bus_rd('h01C, "R4");
        // R5/R8: raw vs masked
        pulse(2'b10, 2'b01);            // tc on ch1 (unmasked), err on ch0 (unmasked)
        bus_rd('h014, "R5");
        bus_rd('h018, "R5");
        bus_rd('h004, "R5");
        bus_rd('h00C, "R5");
        bus_rd('h000, "R8");
        check("R8", "irq masked off", 32'(irq), 0);
        pulse(2'b01, 2'b10);
        check("R8", "irq raised", 32'(irq), 1);
        bus_rd('h000, "R4");
        bus_rd('h004, "R4");
        bus_rd('h00C, "R4");
        // R6: clears
        bus_wr('h008, 32'h0000_0001);
        bus_rd('h014, "R6");
        bus_wr('h010, 32'h0000_0003);
        bus_rd('h018, "R6");
        check("R6", "irq after clears", 32'(irq), 0);
        // R7: set and clear on the same bit in the same cycle
        pulse(2'b01, 2'b00);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 12'h008; bus_wdata = 32'h3;
        tc_set = 2'b01;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; tc_set = 0;
        @(negedge clk);
        bus_rd('h014, "R7");
        check("R7", "irq held", 32'(irq), 1);
        // R9: identification bytes
        for (int i = 0; i < 8; i++) bus_rd('hFE0 + 4*i, "R9");
        // R10: soft request words and unmapped space
        for (int i = 8; i < 12; i++) bus_wr(4*i, 32'hFFFF_FFFF);
        for (int i = 8; i < 12; i++) bus_rd(4*i, "R10");
        bus_wr('h300, 32'h5555_5555);
        bus_wr('h03C, 32'h5555_5555);
        bus_rd('h300, "R10");
        bus_rd('h03C, "R10");
        bus_rd('h030, "R10");
        bus_rd('h014, "R10");
        finish_run();
    end

endmodule